// File: doc/BRIEF.md
# Lane-Wise Byte-Align Funnel Shifter

This unit is a SIMD execution stage for a vector datapath of up to 512 bits, arranged as four independent 128-bit lanes. In every lane it places a lane of the first source above the matching lane of the second source to form a 256-bit value. It moves that value right by a whole number of bytes given by an 8-bit immediate and keeps the low 128 bits. One immediate serves all lanes, and no byte ever moves from one lane into another.

After the shift, a per-byte write mask is applied against the old destination value. In merge mode an unselected byte keeps its old value; in zero mode it becomes zero. Bytes above the selected vector length are always cleared. A narrow legacy mode works on 64-bit operands, ignores the mask and clears everything above bit 63. The result is registered, and an output strobe marks it one clock after the input strobe.

Top module: `vba_align_top`

## Requirements
- R1: In each active 128-bit lane, result byte k (0..15) equals byte k+n of the 32-byte value formed with the second-source lane as bytes 0..15 and the first-source lane as bytes 16..31, where n is the unsigned immediate; a position k+n of 32 or more reads as zero.
- R2: With an immediate of 32 or more, every active lane computes all zeros, so the output is zero unless merge mode keeps old bytes.
- R3: All active lanes use the same immediate, and each lane draws only on the matching lanes of the two sources.
- R4: `vlen_i` selects the width: 0 = legacy 64-bit, 1 = 128 bits (lane 0, mask bits 15:0), 2 = 256 bits (lanes 0..1, mask bits 31:0), 3 = 512 bits (all lanes, mask bits 63:0); output bytes at or above the selected width are zero.
- R5: `mmode_i` selects masking: 0 = off (every active byte written), 1 = merge, 2 or 3 = zero. With masking on, active byte j takes the computed byte when `wmask_i[j]` is 1; otherwise merge keeps byte j of `old_i` and zero mode writes 0.
- R6: In legacy mode the low 64 bits of the two sources form a 16-byte value (first source high), shifted right by n bytes with the low 8 bytes kept; n of 16 or more gives zero, the mask and masking mode have no effect, and bits 511:64 are zero.
- R7: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and the result of that operation appears on `dst_o` in the same cycle.
- R8: While `rst_n` is low, `dst_o` is zero and `valid_o` is low, whatever the other inputs.
- R9: In a cycle after one with `valid_i` low, `dst_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| vlen_i | input | 2 | Vector width select |
| mmode_i | input | 2 | Masking mode select |
| imm_i | input | 8 | Unsigned byte shift count |
| wmask_i | input | 64 | Per-byte write mask |
| src1_i | input | 512 | First source (upper half of each lane pair) |
| src2_i | input | 512 | Second source (lower half of each lane pair) |
| old_i | input | 512 | Previous destination value |
| valid_o | output | 1 | Result strobe |
| dst_o | output | 512 | New destination value |

## Verification
On every cycle the assertions check the strobe timing, the hold of the result between operations, the cleared bytes above each width, and the all-zero outcomes of large counts, of zero mode with an empty mask and of the legacy limit, plus the full keep of the old value under merge with an empty mask. The byte-exact content of a shifted lane, its boundaries at counts 15, 16 and 31, lane independence and the byte-by-byte interleave of random masks can only be shown by the bench scenarios, which compare against a model of concatenation and shifting.

// File: rtl/vba_pkg.sv
package vba_pkg;

    typedef enum logic [1:0] {
        VL_LEG64 = 2'd0,
        VL_128   = 2'd1,
        VL_256   = 2'd2,
        VL_512   = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        MM_OFF   = 2'd0,
        MM_MERGE = 2'd1,
        MM_ZERO  = 2'd2,
        MM_ZERO2 = 2'd3
    } mmode_e;

endpackage

// File: rtl/vba_lane_funnel.sv
module vba_lane_funnel #(
    parameter int LB = 16,
    parameter int CW = 8
) (
    input  logic [LB*8-1:0] hi_i,
    input  logic [LB*8-1:0] lo_i,
    input  logic [CW-1:0]   cnt_i,
    output logic [LB*8-1:0] res_o
);
    localparam int CAT_B = 2 * LB;
    localparam int IW    = $clog2(CAT_B);

    logic [CAT_B*8-1:0] cat;
    assign cat = {hi_i, lo_i};

    for (genvar k = 0; k < LB; k++) begin : g_byte
        logic [CW:0]   idx;
        logic [IW-1:0] sel;
        assign idx = {1'b0, cnt_i} + (CW + 1)'(k);
        assign sel = idx[IW-1:0];
        assign res_o[k*8 +: 8] = (idx < (CW + 1)'(CAT_B)) ? cat[{sel, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/vba_byte_mask.sv
module vba_byte_mask #(
    parameter int NB = 64
) (
    input  logic [NB*8-1:0] calc_i,
    input  logic [NB*8-1:0] old_i,
    input  logic [NB-1:0]   wmask_i,
    input  logic [NB-1:0]   act_i,
    input  logic            msk_on_i,
    input  logic            zero_i,
    output logic [NB*8-1:0] out_o
);
    for (genvar j = 0; j < NB; j++) begin : g_b
        always_comb begin
            if (!act_i[j]) begin
                out_o[j*8 +: 8] = 8'h00;
            end else if (!msk_on_i || wmask_i[j]) begin
                out_o[j*8 +: 8] = calc_i[j*8 +: 8];
            end else if (zero_i) begin
                out_o[j*8 +: 8] = 8'h00;
            end else begin
                out_o[j*8 +: 8] = old_i[j*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/vba_align_top.sv
module vba_align_top #(
    parameter int NLANES = 4,
    parameter int LANE_W = 128,
    parameter int IMM_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid_i,
    input  logic [1:0]                 vlen_i,
    input  logic [1:0]                 mmode_i,
    input  logic [IMM_W-1:0]           imm_i,
    input  logic [NLANES*LANE_W/8-1:0] wmask_i,
    input  logic [NLANES*LANE_W-1:0]   src1_i,
    input  logic [NLANES*LANE_W-1:0]   src2_i,
    input  logic [NLANES*LANE_W-1:0]   old_i,
    output logic                       valid_o,
    output logic [NLANES*LANE_W-1:0]   dst_o
);
    import vba_pkg::*;

    localparam int VW    = NLANES * LANE_W;
    localparam int NB    = VW / 8;
    localparam int LB    = LANE_W / 8;
    localparam int LEG_W = LANE_W / 2;
    localparam int LEG_B = LEG_W / 8;

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] dst;
    } st_t;

    st_t st_d, st_q;

    logic [VW-1:0]    lane_res;
    logic [LEG_W-1:0] leg_res;
    logic [VW-1:0]    calc;
    logic [VW-1:0]    masked;
    logic [NB-1:0]    act;
    logic             is_leg;
    logic             msk_on;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        vba_lane_funnel #(.LB(LB), .CW(IMM_W)) u_fun (
            .hi_i  (src1_i[l*LANE_W +: LANE_W]),
            .lo_i  (src2_i[l*LANE_W +: LANE_W]),
            .cnt_i (imm_i),
            .res_o (lane_res[l*LANE_W +: LANE_W])
        );
    end

    vba_lane_funnel #(.LB(LEG_B), .CW(IMM_W)) u_leg (
        .hi_i  (src1_i[LEG_W-1:0]),
        .lo_i  (src2_i[LEG_W-1:0]),
        .cnt_i (imm_i),
        .res_o (leg_res)
    );

    assign is_leg = (vlen_e'(vlen_i) == VL_LEG64);
    assign msk_on = !is_leg && (mmode_e'(mmode_i) != MM_OFF);
    assign calc   = is_leg ? {{(VW-LEG_W){1'b0}}, leg_res} : lane_res;

    for (genvar j = 0; j < NB; j++) begin : g_act
        localparam int LN = j / LB;
        always_comb begin
            unique case (vlen_e'(vlen_i))
                VL_LEG64: act[j] = (j < LEG_B);
                VL_128:   act[j] = (LN < 1);
                VL_256:   act[j] = (LN < 2);
                default:  act[j] = 1'b1;
            endcase
        end
    end

    vba_byte_mask #(.NB(NB)) u_msk (
        .calc_i   (calc),
        .old_i    (old_i),
        .wmask_i  (wmask_i),
        .act_i    (act),
        .msk_on_i (msk_on),
        .zero_i   (mmode_i[1]),
        .out_o    (masked)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.dst = masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.vld;
    assign dst_o   = st_q.dst;

endmodule

// File: rtl/vba_align_chk.sv
module vba_align_chk #(
    parameter int NLANES = 4,
    parameter int LANE_W = 128,
    parameter int IMM_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       valid_i,
    input logic [1:0]                 vlen_i,
    input logic [1:0]                 mmode_i,
    input logic [IMM_W-1:0]           imm_i,
    input logic [NLANES*LANE_W/8-1:0] wmask_i,
    input logic [NLANES*LANE_W-1:0]   old_i,
    input logic                       valid_o,
    input logic [NLANES*LANE_W-1:0]   dst_o
);
    localparam int VW     = NLANES * LANE_W;
    localparam int LANE_B = LANE_W / 8;
    localparam int BIG    = 2 * LANE_B;
    localparam int LBIG   = LANE_B;

    a_r7_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(dst_o));

    if (NLANES > 1) begin : g_len
        a_r4_len128_upper: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && vlen_i == 2'd1) |=> (dst_o[VW-1:LANE_W] == '0));
    end

    if (NLANES > 2) begin : g_len2
        a_r4_len256_upper: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && vlen_i == 2'd2) |=> (dst_o[VW-1:2*LANE_W] == '0));
    end

    a_r6_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vlen_i == 2'd0) |=> (dst_o[VW-1:LANE_W/2] == '0));

    a_r6_legacy_big: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vlen_i == 2'd0 && int'(imm_i) >= LBIG) |=> (dst_o == '0));

    a_r2_big_count: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vlen_i != 2'd0 && int'(imm_i) >= BIG && mmode_i != 2'd1) |=> (dst_o == '0));

    a_r5_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vlen_i != 2'd0 && mmode_i[1] && wmask_i == '0) |=> (dst_o == '0));

    a_r5_merge_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vlen_i == 2'd3 && mmode_i == 2'd1 && wmask_i == '0) |=> (dst_o == $past(old_i)));

endmodule

bind vba_align_top vba_align_chk #(
    .NLANES (NLANES),
    .LANE_W (LANE_W),
    .IMM_W  (IMM_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .vlen_i  (vlen_i),
    .mmode_i (mmode_i),
    .imm_i   (imm_i),
    .wmask_i (wmask_i),
    .old_i   (old_i),
    .valid_o (valid_o),
    .dst_o   (dst_o)
);

// File: tb/sim_vba_align_top.sv
`timescale 1ns/1ps
module sim_vba_align_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [1:0]   vlen_i = 2'd3;
    logic [1:0]   mmode_i = 2'd0;
    logic [7:0]   imm_i = 8'd0;
    logic [63:0]  wmask_i = '0;
    logic [511:0] src1_i = '0;
    logic [511:0] src2_i = '0;
    logic [511:0] old_i = '0;
    logic         valid_o;
    logic [511:0] dst_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vba_align_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .vlen_i  (vlen_i),
        .mmode_i (mmode_i),
        .imm_i   (imm_i),
        .wmask_i (wmask_i),
        .src1_i  (src1_i),
        .src2_i  (src2_i),
        .old_i   (old_i),
        .valid_o (valid_o),
        .dst_o   (dst_o)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [511:0] model(
        logic [511:0] s1, logic [511:0] s2, logic [511:0] od,
        logic [7:0] n, logic [63:0] m, logic [1:0] vl, logic [1:0] mm);
        logic [511:0] tmp;
        logic [511:0] res;
        logic [255:0] cat;
        logic [127:0] c64;
        int lanes;
        tmp = '0;
        res = '0;
        if (vl == 2'd0) begin
            c64 = {s1[63:0], s2[63:0]};
            if (n < 16) res[63:0] = 64'(c64 >> (int'(n) * 8));
            return res;
        end
        lanes = (vl == 2'd1) ? 1 : (vl == 2'd2) ? 2 : 4;
        for (int l = 0; l < lanes; l++) begin
            cat = {s1[l*128 +: 128], s2[l*128 +: 128]};
            if (n < 32) tmp[l*128 +: 128] = 128'(cat >> (int'(n) * 8));
        end
        for (int j = 0; j < lanes * 16; j++) begin
            if (mm == 2'd0 || m[j]) res[j*8 +: 8] = tmp[j*8 +: 8];
            else if (mm == 2'd1)    res[j*8 +: 8] = od[j*8 +: 8];
            else                    res[j*8 +: 8] = 8'h00;
        end
        return res;
    endfunction

    task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(string tag, logic [7:0] n, logic [1:0] vl, logic [1:0] mm,
                          logic [63:0] m, logic [511:0] s1, logic [511:0] s2, logic [511:0] od);
        @(negedge clk);
        valid_i = 1'b1; imm_i = n; vlen_i = vl; mmode_i = mm;
        wmask_i = m; src1_i = s1; src2_i = s2; old_i = od;
        @(negedge clk);
        valid_i = 1'b0;
        check({tag, " R7 strobe"}, {511'd0, valid_o}, 512'd1);
        check(tag, dst_o, model(s1, s2, od, n, m, vl, mm));
    endtask

    task automatic t_reset();
        valid_i = 1'b1; src1_i = rnd512(); src2_i = rnd512(); imm_i = 8'd3;
        repeat (3) @(negedge clk);
        check("R8 reset data", dst_o, '0);
        check("R8 reset strobe", {511'd0, valid_o}, '0);
        valid_i = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_counts();
        int cnts[6] = '{0, 15, 16, 31, 32, 255};
        foreach (cnts[i])
            run_op($sformatf("R1 R2 count %0d", cnts[i]), 8'(cnts[i]), 2'd3, 2'd0, '0,
                   rnd512(), rnd512(), rnd512());
        for (int i = 0; i < 8; i++)
            run_op("R1 random count", 8'($urandom_range(0, 40)), 2'd3, 2'd0, '0,
                   rnd512(), rnd512(), rnd512());
    endtask

    task automatic t_lanes();
        logic [511:0] a, b;
        for (int i = 0; i < 64; i++) begin
            a[i*8 +: 8] = 8'(8'h80 + i);
            b[i*8 +: 8] = 8'(i);
        end
        run_op("R3 lane pattern n5", 8'd5, 2'd3, 2'd0, '0, a, b, '1);
        run_op("R3 lane pattern n20", 8'd20, 2'd3, 2'd0, '0, a, b, '1);
    endtask

    task automatic t_vlen();
        for (int v = 1; v < 4; v++)
            for (int k = 0; k < 3; k++)
                run_op($sformatf("R4 width %0d", v), 8'($urandom_range(0, 33)), 2'(v), 2'd0,
                       {$urandom, $urandom}, rnd512(), rnd512(), rnd512());
    endtask

    task automatic t_mask();
        for (int v = 1; v < 4; v++) begin
            run_op("R5 merge random", 8'd7, 2'(v), 2'd1, {$urandom, $urandom}, rnd512(), rnd512(), rnd512());
            run_op("R5 zero random", 8'd9, 2'(v), 2'd2, {$urandom, $urandom}, rnd512(), rnd512(), rnd512());
            run_op("R5 zero alt", 8'd16, 2'(v), 2'd3, {$urandom, $urandom}, rnd512(), rnd512(), rnd512());
        end
        run_op("R5 merge empty", 8'd4, 2'd3, 2'd1, '0, rnd512(), rnd512(), rnd512());
        run_op("R5 zero empty", 8'd4, 2'd3, 2'd2, '0, rnd512(), rnd512(), rnd512());
        run_op("R2 big merge", 8'd40, 2'd3, 2'd1, {$urandom, $urandom}, rnd512(), rnd512(), rnd512());
    endtask

    task automatic t_legacy();
        int cnts[6] = '{0, 3, 7, 8, 15, 16};
        foreach (cnts[i])
            run_op($sformatf("R6 legacy count %0d", cnts[i]), 8'(cnts[i]), 2'd0,
                   2'(i % 4), {$urandom, $urandom}, rnd512(), rnd512(), rnd512());
        run_op("R6 legacy 255", 8'd255, 2'd0, 2'd2, '0, rnd512(), rnd512(), rnd512());
    endtask

    task automatic t_hold();
        logic [511:0] prev;
        run_op("R9 setup", 8'd2, 2'd3, 2'd0, '0, rnd512(), rnd512(), rnd512());
        prev = dst_o;
        src1_i = rnd512(); src2_i = rnd512(); old_i = rnd512(); imm_i = 8'd1;
        repeat (2) @(negedge clk);
        check("R9 hold data", dst_o, prev);
        check("R7 idle strobe", {511'd0, valid_o}, '0);
    endtask

    task automatic t_rst_mid();
        run_op("R8 pre", 8'd1, 2'd3, 2'd0, '0, rnd512(), rnd512(), rnd512());
        @(negedge clk);
        valid_i = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R8 midrun data", dst_o, '0);
        check("R8 midrun strobe", {511'd0, valid_o}, '0);
        @(negedge clk);
        valid_i = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_counts();
        t_lanes();
        t_vlen();
        t_mask();
        t_legacy();
        t_hold();
        t_rst_mid();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule